// File: doc/BRIEF.md
# Memory-Mapped Bus Address Decoder

The block connects one memory-mapped bus master to several target ports. Each target owns an address window given by a base value and a mask, and a target is chosen when the masked address equals its base. Targets are tried in index order and the lowest matching index wins, so windows may overlap and a small window can carve a region out of a larger one. The chosen target sees a word offset local to its own window: the address bits outside the mask, shifted right by that target's word-size bit count.

A request is captured in the first cycle it is seen and is replayed from the captured copy until the selected target stops stalling. A request that hits no window, one with low address bits set inside the target's word size, or one with both read and write raised is not passed on. It is retired in one cycle with waitrequest low and zero read data, and every target receives an abort pulse. These faults set a sticky error flag with a code and the failing address, kept until a clear input. A master that changes its request while a transfer is pending also sets the flag.

The controller has three states. IDLE accepts a request (accept: IDLE to BUSY) or traps a bad one (trap: IDLE to FAULT). BUSY drives the captured request to the target and leaves when the target's waitrequest is low (release: BUSY to IDLE). FAULT lasts one cycle (retire: FAULT to IDLE).

Top module: `mmdec_router`

## Requirements
- R1: The target with the lowest index i for which (address AND mask_i) equals base_i is selected. At most one bit of `s_sel` is high, and only in BUSY.
- R2: `s_off` equals (address AND NOT mask_i) shifted right by the word bits of target i while that target is selected.
- R3: A read returns the selected target's `s_rdata` slice on `m_rdata`. A write presents the master's write data and 4-bit byte enable unchanged on `s_wdata` and `s_be`.
- R4: `m_wait` is high in the IDLE cycle that sees a request and then follows the selected target's `s_wait`. The first cycle with the target's wait low completes the transfer, so a target that stalls L cycles gives a transfer of L+2 cycles.
- R5: During BUSY, the address, strobes, data and enables sent to the target come from the captured copy and do not follow later changes on the master inputs.
- R6: If any master request input differs from the captured copy during BUSY, the error flag is set with code 3 and the master's current address.
- R7: A cycle with read and write both high is trapped with error code 3 and retired in two cycles with `m_wait` low in the second.
- R8: An address matching no window is trapped with error code 1. It takes two cycles, with `m_rdata` zero in the second, `s_abort` high for one cycle, and no target selected.
- R9: An address with a nonzero bit below the selected target's word-bit count is trapped with error code 2, exactly like R8.
- R10: The error flag, code and address hold the first fault after a clear. Later faults do not overwrite them, and a pulse on `err_clr` clears the flag.
- R11: After reset, `m_wait`, `s_sel`, `s_rd`, `s_wr`, `s_off`, `s_abort` and `err_flag` are zero.
- R12: With neither read nor write raised in IDLE, `m_wait` is low and no target is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| m_addr | input | AW | Master byte address |
| m_rd | input | 1 | Master read strobe |
| m_wr | input | 1 | Master write strobe |
| m_wdata | input | DW | Master write data |
| m_be | input | BW | Master byte enables |
| m_rdata | output | DW | Read data to master |
| m_wait | output | 1 | Stall to master |
| s_sel | output | N | One-hot target select |
| s_rd | output | 1 | Read strobe to targets |
| s_wr | output | 1 | Write strobe to targets |
| s_off | output | AW | Target-local word offset |
| s_wdata | output | DW | Write data to targets |
| s_be | output | BW | Byte enables to targets |
| s_rdata | input | N*DW | Read data from targets, target i at bits i*DW |
| s_wait | input | N | Stall from each target |
| s_abort | output | 1 | Abandon-operation pulse to all targets |
| err_clr | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky error flag |
| err_code | output | 2 | 1 hole, 2 misaligned, 3 protocol |
| err_addr | output | AW | Address of the first fault |

## Verification
Reads and writes go to three targets with stalls of zero, two and one cycles. The second and third targets overlap, so the same upper address bits reach different targets depending on the low bits, which separates first-match priority from last-match and shows each target's own shift in the offset. Hole, misaligned and dual-strobe requests are each issued with and without a clear in between, which tells sticky first-fault capture apart from overwriting. A write whose data changes in mid-stall shows whether the target sees the captured copy or the live input.

// File: rtl/mmdec_pkg.sv
package mmdec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_FAULT = 2'd2
    } rt_state_e;

    typedef enum logic [1:0] {
        EC_NONE  = 2'd0,
        EC_HOLE  = 2'd1,
        EC_ALIGN = 2'd2,
        EC_PROTO = 2'd3
    } rt_err_e;
endpackage

// File: rtl/mmdec_decode.sv
module mmdec_decode #(
    parameter int N  = 3,
    parameter int AW = 16,
    parameter int IW = 2,
    parameter logic [N*AW-1:0] BASE  = '0,
    parameter logic [N*AW-1:0] MASK  = '0,
    parameter logic [N*4-1:0]  WBITS = '0
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [IW-1:0] idx,
    output logic          misalign,
    output logic [AW-1:0] offset
);
    logic [N-1:0]  match;
    logic [N-1:0]  low_set;
    logic [AW-1:0] offs [N];

    for (genvar gi = 0; gi < N; gi++) begin : g_win
        localparam logic [AW-1:0] B  = BASE[gi*AW +: AW];
        localparam logic [AW-1:0] M  = MASK[gi*AW +: AW];
        localparam int            WB = int'(WBITS[gi*4 +: 4]);
        localparam logic [AW-1:0] LOWM = (AW'(1) << WB) - AW'(1);

        assign match[gi]   = (addr & M) == B;
        assign low_set[gi] = |(addr & LOWM);
        assign offs[gi]    = (addr & ~M) >> WB;

        // R1: a window base must lie inside its own mask
        initial begin : cfg_chk
            p_base_in_mask_r1: assert ((B & M) == B)
                else $error("window %0d base outside mask", gi);
        end
    end

    // lowest index wins: scan downward so the last write is the lowest
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end

    assign misalign = hit & low_set[idx];
    assign offset   = offs[idx];
endmodule

// File: rtl/mmdec_ctrl.sv
module mmdec_ctrl
    import mmdec_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int BW = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] m_addr,
    input  logic          m_rd,
    input  logic          m_wr,
    input  logic [DW-1:0] m_wdata,
    input  logic [BW-1:0] m_be,
    input  logic          dec_hit,
    input  logic [IW-1:0] dec_idx,
    input  logic          dec_mis,
    input  logic          slv_wait,
    output rt_state_e     state,
    output logic [AW-1:0] lat_addr,
    output logic          lat_rd,
    output logic          lat_wr,
    output logic [DW-1:0] lat_wdata,
    output logic [BW-1:0] lat_be,
    output logic [IW-1:0] sel_idx,
    output logic          ev,
    output rt_err_e       ev_code,
    output logic [AW-1:0] ev_addr
);
    rt_state_e nxt;
    logic      req;
    logic      drift;

    assign req   = m_rd | m_wr;
    assign drift = (m_addr != lat_addr) || (m_rd != lat_rd) || (m_wr != lat_wr)
                || (m_wdata != lat_wdata) || (m_be != lat_be);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt     = state;
        ev      = 1'b0;
        ev_code = EC_NONE;
        ev_addr = m_addr;
        unique case (state)
            ST_IDLE: begin
                if (m_rd && m_wr) begin
                    nxt = ST_FAULT; ev = 1'b1; ev_code = EC_PROTO;
                end else if (req && !dec_hit) begin
                    nxt = ST_FAULT; ev = 1'b1; ev_code = EC_HOLE;
                end else if (req && dec_mis) begin
                    nxt = ST_FAULT; ev = 1'b1; ev_code = EC_ALIGN;
                end else if (req) begin
                    nxt = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (drift) begin
                    ev = 1'b1; ev_code = EC_PROTO;
                end
                if (!slv_wait) nxt = ST_IDLE;
            end
            ST_FAULT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_rd    <= 1'b0;
            lat_wr    <= 1'b0;
            lat_wdata <= '0;
            lat_be    <= '0;
            sel_idx   <= '0;
        end else if (state == ST_IDLE && req) begin
            lat_addr  <= m_addr;
            lat_rd    <= m_rd;
            lat_wr    <= m_wr;
            lat_wdata <= m_wdata;
            lat_be    <= m_be;
            sel_idx   <= dec_idx;
        end
    end

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !slv_wait) |=> state == ST_IDLE);

    p_hold_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && slv_wait) |=> ($stable(lat_addr) && $stable(lat_wdata)
                                            && $stable(lat_be) && $stable(sel_idx)));

    p_fault_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FAULT |=> state == ST_IDLE);
endmodule

// File: rtl/mmdec_errlog.sv
module mmdec_errlog
    import mmdec_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ev,
    input  rt_err_e       ev_code,
    input  logic [AW-1:0] ev_addr,
    output logic          flag,
    output logic [1:0]    code,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
            code <= 2'd0;
            addr <= '0;
        end else if (ev && (!flag || clr)) begin
            flag <= 1'b1;
            code <= ev_code;
            addr <= ev_addr;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> (flag && $stable(addr) && $stable(code)));
endmodule

// File: rtl/mmdec_router.sv
module mmdec_router
    import mmdec_pkg::*;
#(
    parameter int N  = 3,
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int BW = 4,
    parameter logic [N*AW-1:0] BASE  = {16'h1000, 16'h1000, 16'h0000},
    parameter logic [N*AW-1:0] MASK  = {16'hF000, 16'hFF00, 16'hF000},
    parameter logic [N*4-1:0]  WBITS = {4'd2, 4'd1, 4'd2}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   m_addr,
    input  logic            m_rd,
    input  logic            m_wr,
    input  logic [DW-1:0]   m_wdata,
    input  logic [BW-1:0]   m_be,
    output logic [DW-1:0]   m_rdata,
    output logic            m_wait,
    output logic [N-1:0]    s_sel,
    output logic            s_rd,
    output logic            s_wr,
    output logic [AW-1:0]   s_off,
    output logic [DW-1:0]   s_wdata,
    output logic [BW-1:0]   s_be,
    input  logic [N*DW-1:0] s_rdata,
    input  logic [N-1:0]    s_wait,
    output logic            s_abort,
    input  logic            err_clr,
    output logic            err_flag,
    output logic [1:0]      err_code,
    output logic [AW-1:0]   err_addr
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    rt_state_e     state;
    logic [AW-1:0] lat_addr;
    logic          lat_rd, lat_wr;
    logic [DW-1:0] lat_wdata;
    logic [BW-1:0] lat_be;
    logic [IW-1:0] sel_idx;
    logic [AW-1:0] dec_addr;
    logic          dec_hit, dec_mis;
    logic [IW-1:0] dec_idx;
    logic [AW-1:0] dec_off;
    logic          slv_wait;
    logic          ev;
    rt_err_e       ev_code;
    logic [AW-1:0] ev_addr;
    logic          busy;

    assign busy     = (state == ST_BUSY);
    assign dec_addr = (state == ST_IDLE) ? m_addr : lat_addr;
    assign slv_wait = s_wait[sel_idx];

    mmdec_decode #(.N(N), .AW(AW), .IW(IW), .BASE(BASE), .MASK(MASK), .WBITS(WBITS)) u_dec (
        .addr(dec_addr), .hit(dec_hit), .idx(dec_idx), .misalign(dec_mis), .offset(dec_off)
    );

    mmdec_ctrl #(.AW(AW), .DW(DW), .BW(BW), .IW(IW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .m_addr(m_addr), .m_rd(m_rd), .m_wr(m_wr), .m_wdata(m_wdata), .m_be(m_be),
        .dec_hit(dec_hit), .dec_idx(dec_idx), .dec_mis(dec_mis), .slv_wait(slv_wait),
        .state(state), .lat_addr(lat_addr), .lat_rd(lat_rd), .lat_wr(lat_wr),
        .lat_wdata(lat_wdata), .lat_be(lat_be), .sel_idx(sel_idx),
        .ev(ev), .ev_code(ev_code), .ev_addr(ev_addr)
    );

    mmdec_errlog #(.AW(AW)) u_err (
        .clk(clk), .rst_n(rst_n), .clr(err_clr), .ev(ev), .ev_code(ev_code), .ev_addr(ev_addr),
        .flag(err_flag), .code(err_code), .addr(err_addr)
    );

    for (genvar gi = 0; gi < N; gi++) begin : g_sel
        assign s_sel[gi] = busy && (sel_idx == IW'(gi));
    end

    always_comb begin
        m_wait  = 1'b0;
        m_rdata = '0;
        unique case (state)
            ST_IDLE:  m_wait = m_rd | m_wr;
            ST_BUSY: begin
                m_wait = slv_wait;
                if (lat_rd) m_rdata = s_rdata[int'(sel_idx)*DW +: DW];
            end
            ST_FAULT: m_wait = 1'b0;
            default:  m_wait = 1'b0;
        endcase
    end

    assign s_rd    = busy & lat_rd;
    assign s_wr    = busy & lat_wr;
    assign s_off   = busy ? dec_off : '0;
    assign s_wdata = lat_wdata;
    assign s_be    = lat_be;
    assign s_abort = (state == ST_FAULT);

    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_sel));

    p_abort_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_abort |-> (s_sel == '0 && !m_wait && m_rdata == '0));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !m_rd && !m_wr) |-> (!m_wait && s_sel == '0));

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_rd && s_wr));
endmodule

// File: tb/mmdec_router_test.sv
module mmdec_router_test;
    localparam int N  = 3;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int BW = 4;
    localparam int LAT [N] = '{0, 2, 1};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   m_addr = '0;
    logic            m_rd = 1'b0, m_wr = 1'b0;
    logic [DW-1:0]   m_wdata = '0;
    logic [BW-1:0]   m_be = '0;
    logic [DW-1:0]   m_rdata;
    logic            m_wait;
    logic [N-1:0]    s_sel;
    logic            s_rd, s_wr;
    logic [AW-1:0]   s_off;
    logic [DW-1:0]   s_wdata;
    logic [BW-1:0]   s_be;
    logic [N*DW-1:0] s_rdata;
    logic [N-1:0]    s_wait;
    logic            s_abort;
    logic            err_clr = 1'b0;
    logic            err_flag;
    logic [1:0]      err_code;
    logic [AW-1:0]   err_addr;

    int nchk = 0, nfail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mmdec_router uut (.*);

    // target models
    int            cnt    [N];
    int            wr_cnt [N];
    logic [AW-1:0] wr_off [N];
    logic [DW-1:0] wr_dat [N];
    logic [BW-1:0] wr_be  [N];
    int            sel_seen = 0;

    for (genvar gi = 0; gi < N; gi++) begin : g_tgt
        assign s_wait[gi] = s_sel[gi] && (cnt[gi] < LAT[gi]);
        assign s_rdata[gi*DW +: DW] = {8'(8'hA0 + gi), 8'h00, s_off};
        initial begin cnt[gi] = 0; wr_cnt[gi] = 0; end
        always @(posedge clk) begin
            if (s_sel[gi]) begin
                sel_seen <= sel_seen + 1;
                cnt[gi]  <= cnt[gi] + 1;
                if (!s_wait[gi] && s_wr) begin
                    wr_cnt[gi] <= wr_cnt[gi] + 1;
                    wr_off[gi] <= s_off;
                    wr_dat[gi] <= s_wdata;
                    wr_be[gi]  <= s_be;
                end
            end else begin
                cnt[gi] <= 0;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input logic [AW-1:0] a, input logic rd, input logic wr,
                        input logic [DW-1:0] wd, input logic [BW-1:0] be,
                        output logic [DW-1:0] rdata, output int cyc, output bit ab);
        @(negedge clk);
        m_addr = a; m_rd = rd; m_wr = wr; m_wdata = wd; m_be = be;
        cyc = 0; ab = 1'b0;
        forever begin
            #1;
            cyc++;
            if (s_abort) ab = 1'b1;
            if (!m_wait) begin rdata = m_rdata; break; end
            @(negedge clk);
        end
        @(posedge clk); #1;
        m_rd = 1'b0; m_wr = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        chk("R10", "flag after clear", 32'(err_flag), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11", "m_wait", 32'(m_wait), 0);
        chk("R11", "s_sel", 32'(s_sel), 0);
        chk("R11", "strobes", {30'd0, s_rd, s_wr}, 0);
        chk("R11", "s_off", 32'(s_off), 0);
        chk("R11", "abort/flag", {30'd0, s_abort, err_flag}, 0);
    endtask

    task automatic t_reads();
        logic [DW-1:0] rd; int cyc; bit ab;
        xfer(16'h0124, 1, 0, '0, '0, rd, cyc, ab);
        chk("R2", "target0 read data/offset", rd, 32'hA000_0049);
        chk("R4", "target0 cycles", cyc, 2);
        xfer(16'h1036, 1, 0, '0, '0, rd, cyc, ab);
        chk("R1", "target1 wins overlap", rd, 32'hA100_001B);
        chk("R4", "target1 cycles", cyc, 4);
        xfer(16'h1208, 1, 0, '0, '0, rd, cyc, ab);
        chk("R3", "target2 read data", rd, 32'hA200_0082);
        chk("R4", "target2 cycles", cyc, 3);
        chk("R1", "no fault on good reads", 32'(err_flag), 0);
    endtask

    task automatic t_writes();
        logic [DW-1:0] rd; int cyc; bit ab;
        xfer(16'h10FE, 0, 1, 32'hDEAD_BEEF, 4'b0101, rd, cyc, ab);
        @(negedge clk);
        chk("R3", "target1 write count", wr_cnt[1], 1);
        chk("R3", "target1 write data", wr_dat[1], 32'hDEAD_BEEF);
        chk("R3", "target1 byte enable", 32'(wr_be[1]), 32'h5);
        chk("R2", "target1 write offset", 32'(wr_off[1]), 32'h7F);
        xfer(16'h1100, 0, 1, 32'h1234_5678, 4'b1000, rd, cyc, ab);
        @(negedge clk);
        chk("R1", "target2 gets 0x1100", wr_cnt[2], 1);
        chk("R2", "target2 write offset", 32'(wr_off[2]), 32'h40);
        chk("R3", "target2 byte enable", 32'(wr_be[2]), 32'h8);
    endtask

    task automatic t_faults();
        logic [DW-1:0] rd; int cyc; bit ab; int seen0;
        seen0 = sel_seen;
        xfer(16'h3000, 1, 0, '0, '0, rd, cyc, ab);
        @(negedge clk);
        chk("R8", "hole cycles", cyc, 2);
        chk("R8", "hole rdata", rd, 0);
        chk("R8", "hole abort", 32'(ab), 1);
        chk("R8", "hole selects none", sel_seen - seen0, 0);
        chk("R8", "hole code", 32'(err_code), 1);
        chk("R8", "hole addr", 32'(err_addr), 32'h3000);
        xfer(16'h0002, 1, 0, '0, '0, rd, cyc, ab);
        @(negedge clk);
        chk("R9", "misaligned cycles", cyc, 2);
        chk("R10", "first fault kept code", 32'(err_code), 1);
        chk("R10", "first fault kept addr", 32'(err_addr), 32'h3000);
        clear_err();
        xfer(16'h1001, 0, 1, 32'hFFFF_FFFF, 4'hF, rd, cyc, ab);
        @(negedge clk);
        chk("R9", "misaligned code", 32'(err_code), 2);
        chk("R9", "misaligned addr", 32'(err_addr), 32'h1001);
        chk("R9", "misaligned abort", 32'(ab), 1);
        chk("R9", "no write reached target1", wr_cnt[1], 1);
        clear_err();
        xfer(16'h0010, 1, 1, 32'h0, 4'hF, rd, cyc, ab);
        @(negedge clk);
        chk("R7", "dual strobe cycles", cyc, 2);
        chk("R7", "dual strobe code", 32'(err_code), 3);
        chk("R7", "dual strobe flag", 32'(err_flag), 1);
        clear_err();
    endtask

    task automatic t_drift();
        @(negedge clk);
        m_addr = 16'h1040; m_wr = 1'b1; m_wdata = 32'hAAAA_5555; m_be = 4'hF;
        @(negedge clk);
        m_wdata = 32'h0BAD_0BAD;
        while (m_wait) @(negedge clk);
        @(posedge clk); #1;
        m_wr = 1'b0;
        @(negedge clk);
        chk("R5", "target1 saw captured data", wr_dat[1], 32'hAAAA_5555);
        chk("R6", "drift flag", 32'(err_flag), 1);
        chk("R6", "drift code", 32'(err_code), 3);
        chk("R6", "drift addr", 32'(err_addr), 32'h1040);
        clear_err();
    endtask

    task automatic t_idle();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R12", "idle m_wait", 32'(m_wait), 0);
            chk("R12", "idle s_sel", 32'(s_sel), 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_idle();
        t_reads();
        t_writes();
        t_faults();
        t_drift();
        t_idle();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule